// File: doc/BRIEF.md
# Single-Bus Accumulator Computer

This block is a small 8-bit stored-program computer. One shared 8-bit bus links a 4-bit program counter, a memory address register, a 16-word by 8-bit memory for both code and data, an instruction register, an accumulator, a B operand register, an add/subtract unit and an 8-bit result port. A controller decides in each cycle which single unit may put a value on the bus and which units capture it.

Every instruction takes exactly six cycles. The first three fetch the word that the program counter points at and then advance the counter. The last three carry out the operation named by the upper nibble. A test harness fills the memory through a write port while the clear input is held low. It then releases clear and waits for the halted flag. After that it reads the value last copied to the result port.

Top module: `acc_core`

## Requirements
- R1: An instruction word holds the opcode in bits 7:4 and a memory address in bits 3:0. The opcodes are 0x0 load, 0x1 add, 0x2 subtract, 0xE copy the accumulator to the result port, and 0xF halt.
- R2: Each instruction takes six clock cycles. After clear is released, `halted` first reads high after clock edge 6·n, where n is the number of instructions executed up to and including the halt.
- R3: After clear, execution starts at address 0. The program counter advances by one for each instruction fetched.
- R4: Load (0x0) copies the memory word at its address into the accumulator.
- R5: Add (0x1) and subtract (0x2) combine the accumulator with the memory word at their address. The result wraps modulo 256 and no carry is kept.
- R6: Opcode 0xE copies the accumulator to `out_val`. `out_val` changes at no other time.
- R7: After a halt, `halted` stays high and `out_val` stays fixed until the next clear, even if the memory is rewritten.
- R8: While `clr_n` is low, `out_val` and `halted` read 0. Clear also zeroes the program counter, the accumulator and the B register.
- R9: An opcode outside the five listed changes nothing visible. Execution moves on to the next word.
- R10: No more than one source drives the shared bus in any cycle.
- R11: When `ld_en` is high, `ld_data` is written into the memory word at `ld_addr` on the rising clock edge.
- R12: Code `09 1A 1B 1C 2D E0 F0` with data 16, 20, 24, 28, 32 at addresses 9 to 13 leaves 56 on `out_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear. It takes effect at once and is released in step with the clock |
| ld_en | input | 1 | Memory write enable for the preload port |
| ld_addr | input | 4 | Preload write address |
| ld_data | input | 8 | Preload write data |
| out_val | output | 8 | Result port register |
| halted | output | 1 | High once a halt instruction has run |

## Verification
Directed programs come first. The worked sum checks the whole fetch and execute path against a known value. A program whose only instructions are a copy and a halt shows whether clear really zeroes the accumulator. Near-overflow additions and a subtraction that goes below zero show whether results wrap. Programs sprinkled with undefined opcodes show whether those words are skipped without side effects. Seeded random programs then mix loads, arithmetic, copies and undefined words, some of them reading their own code as data. These compare the final port value and the exact halt cycle with a bench-side instruction model, which separates faults in sequencing from faults in arithmetic.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD = 4'h0;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OPC_SHOW = 4'hE;
  localparam logic [OP_W-1:0] OPC_STOP = 4'hF;

  typedef enum logic [2:0] {
    ST_T1, ST_T2, ST_T3, ST_T4, ST_T5, ST_T6
  } step_e;

  typedef struct packed {
    logic pc_inc;
    logic pc_oe;
    logic mar_ld;
    logic ram_oe;
    logic ir_ld;
    logic ir_oe;
    logic acc_ld;
    logic acc_oe;
    logic alu_sub;
    logic alu_oe;
    logic b_ld;
    logic out_ld;
  } ctrl_t;
endpackage

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl,
  output logic            halted
);
  step_e step_q, step_d;
  logic  halt_q, halt_d;

  always_comb begin
    ctrl   = '0;
    step_d = step_q;
    halt_d = halt_q;
    if (!halt_q) begin
      step_d = (step_q == ST_T6) ? ST_T1 : step_e'(step_q + 3'd1);
      unique case (step_q)
        ST_T1: begin ctrl.pc_oe = 1'b1;  ctrl.mar_ld = 1'b1; end
        ST_T2: ctrl.pc_inc = 1'b1;
        ST_T3: begin ctrl.ram_oe = 1'b1; ctrl.ir_ld = 1'b1; end
        ST_T4: begin
          if (opcode == OPC_LOAD || opcode == OPC_ADD || opcode == OPC_SUB) begin
            ctrl.ir_oe  = 1'b1;
            ctrl.mar_ld = 1'b1;
          end else if (opcode == OPC_SHOW) begin
            ctrl.acc_oe = 1'b1;
            ctrl.out_ld = 1'b1;
          end else if (opcode == OPC_STOP) begin
            halt_d = 1'b1;
          end
        end
        ST_T5: begin
          if (opcode == OPC_LOAD) begin
            ctrl.ram_oe = 1'b1;
            ctrl.acc_ld = 1'b1;
          end else if (opcode == OPC_ADD || opcode == OPC_SUB) begin
            ctrl.ram_oe = 1'b1;
            ctrl.b_ld   = 1'b1;
          end
        end
        ST_T6: begin
          if (opcode == OPC_ADD || opcode == OPC_SUB) begin
            ctrl.alu_oe  = 1'b1;
            ctrl.acc_ld  = 1'b1;
            ctrl.alu_sub = (opcode == OPC_SUB);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_T1;
      halt_q <= 1'b0;
    end else begin
      step_q <= step_d;
      halt_q <= halt_d;
    end
  end

  assign halted = halt_q;
endmodule

// File: rtl/acc_core_ram.sv
module acc_core_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  always_comb y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     clr_n,
  input  logic                     ld_en,
  input  logic [DATA_W-OP_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  output logic [DATA_W-1:0]        out_val,
  output logic                     halted
);
  localparam int ADDR_W = DATA_W - OP_W;
  localparam int NDRV   = 5;

  logic [1:0]        sync_q;
  logic              rst_core_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] bus, ram_rd, alu_y;
  logic [NDRV-1:0]   drv_vec;

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] ir_q, ir_d, acc_q, acc_d, b_q, b_d, out_q, out_d;

  // clear: asserted at once, released on the clock
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_core_n = sync_q[1];

  acc_core_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .opcode (ir_q[DATA_W-1 -: OP_W]),
    .ctrl   (ctrl),
    .halted (halted)
  );

  acc_core_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (mar_q),
    .rd_data (ram_rd)
  );

  acc_core_alu #(.DW(DATA_W)) u_alu (
    .a   (acc_q),
    .b   (b_q),
    .sub (ctrl.alu_sub),
    .y   (alu_y)
  );

  assign drv_vec = {ctrl.pc_oe, ctrl.ram_oe, ctrl.ir_oe, ctrl.acc_oe, ctrl.alu_oe};

  // gated-OR bus stands in for tri-state drivers
  always_comb begin
    bus = ({DATA_W{ctrl.pc_oe}}  & {{OP_W{1'b0}}, pc_q})
        | ({DATA_W{ctrl.ram_oe}} & ram_rd)
        | ({DATA_W{ctrl.ir_oe}}  & {{OP_W{1'b0}}, ir_q[ADDR_W-1:0]})
        | ({DATA_W{ctrl.acc_oe}} & acc_q)
        | ({DATA_W{ctrl.alu_oe}} & alu_y);
  end

  always_comb begin
    pc_d  = ctrl.pc_inc ? pc_q + 1'b1       : pc_q;
    mar_d = ctrl.mar_ld ? bus[ADDR_W-1:0]   : mar_q;
    ir_d  = ctrl.ir_ld  ? bus               : ir_q;
    acc_d = ctrl.acc_ld ? bus               : acc_q;
    b_d   = ctrl.b_ld   ? bus               : b_q;
    out_d = ctrl.out_ld ? bus               : out_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      ir_q  <= ir_d;
      acc_q <= acc_d;
      b_q   <= b_d;
      out_q <= out_d;
    end
  end

  assign out_val = out_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int NDRV = 5
) (
  input logic            clk,
  input logic            rst_n,
  input ctrl_t           c,
  input logic [NDRV-1:0] drv,
  input logic [AW-1:0]   pc_q,
  input logic [DW-1:0]   acc_q,
  input logic [DW-1:0]   b_q,
  input logic [DW-1:0]   out_q,
  input logic            halted
);
  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(out_q));

  p_out_from_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c.out_ld |=> (out_q == $past(acc_q)));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !c.out_ld |=> $stable(out_q));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c.pc_inc |=> (pc_q == AW'($past(pc_q) + 1'b1)));

  p_add_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c.acc_ld && c.alu_oe && !c.alu_sub) |=>
      (acc_q == DW'($past(acc_q) + $past(b_q))));

  p_sub_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c.acc_ld && c.alu_oe && c.alu_sub) |=>
      (acc_q == DW'($past(acc_q) - $past(b_q))));
endmodule

bind acc_core acc_core_chk #(.DW(DATA_W), .AW(ADDR_W), .NDRV(NDRV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .c      (ctrl),
  .drv    (drv_vec),
  .pc_q   (pc_q),
  .acc_q  (acc_q),
  .b_q    (b_q),
  .out_q  (out_q),
  .halted (halted)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n;
  logic       ld_en;
  logic [3:0] ld_addr;
  logic [7:0] ld_data;
  logic [7:0] out_val;
  logic       halted;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .clr_n(clr_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .out_val(out_val), .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // instruction-level model of the requirements; returns final port and count
  function automatic void model(output logic [7:0] res, output int n);
    logic [7:0] acc = 8'd0;
    logic [3:0] pc  = 4'd0;
    res = 8'd0;
    n   = 0;
    for (int s = 0; s < 64; s++) begin
      logic [7:0] w = img[pc];
      pc = pc + 4'd1;
      n++;
      case (w[7:4])
        4'h0: acc = img[w[3:0]];
        4'h1: acc = acc + img[w[3:0]];
        4'h2: acc = acc - img[w[3:0]];
        4'hE: res = acc;
        4'hF: break;
        default: ;
      endcase
    end
  endfunction

  task automatic run_img(input string tag);
    logic [7:0] exp_out;
    int         exp_n;
    int         cyc;
    logic [7:0] held;
    model(exp_out, exp_n);
    @(negedge clk);
    clr_n = 1'b0;
    for (int a = 0; a < 16; a++) begin
      ld_en = 1'b1; ld_addr = 4'(a); ld_data = img[a];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    chk({"R8 out during clear ", tag}, int'(out_val), 0);
    chk({"R8 halted during clear ", tag}, int'(halted), 0);
    clr_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk({"R2 R3 halt edge ", tag}, cyc, 6 * exp_n);
    chk({"R4 R5 R6 R11 result ", tag}, int'(out_val), int'(exp_out));
    held = out_val;
    ld_en = 1'b1; ld_addr = 4'd0; ld_data = 8'hE0;
    @(negedge clk);
    ld_en = 1'b0;
    repeat (12) @(negedge clk);
    chk({"R7 out frozen ", tag}, int'(out_val), int'(held));
    chk({"R7 halted kept ", tag}, int'(halted), 1);
  endtask

  task automatic clear_img();
    for (int a = 0; a < 16; a++) img[a] = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    clr_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);

    // R12, R1: worked sum
    clear_img();
    img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'h1B; img[3] = 8'h1C;
    img[4] = 8'h2D; img[5] = 8'hE0; img[6] = 8'hF0;
    img[9] = 8'd16; img[10] = 8'd20; img[11] = 8'd24; img[12] = 8'd28; img[13] = 8'd32;
    run_img("R12 sum");
    chk("R12 fixed value", int'(out_val), 56);

    // R8: clear zeroes accumulator
    clear_img();
    img[0] = 8'hE0; img[1] = 8'hF0;
    run_img("R8 acc cleared");
    chk("R8 acc zero after clear", int'(out_val), 0);

    // R5: wrap on add and subtract
    clear_img();
    img[0] = 8'h08; img[1] = 8'h19; img[2] = 8'hE0; img[3] = 8'hF0;
    img[8] = 8'd200; img[9] = 8'd100;
    run_img("R5 add wrap");
    chk("R5 add wraps", int'(out_val), 44);

    clear_img();
    img[0] = 8'h0A; img[1] = 8'h2B; img[2] = 8'hE0; img[3] = 8'hF0;
    img[10] = 8'd10; img[11] = 8'd20;
    run_img("R5 sub wrap");
    chk("R5 sub wraps", int'(out_val), 246);

    // R9: undefined opcodes skipped
    clear_img();
    img[0] = 8'h09; img[1] = 8'h5A; img[2] = 8'h3B; img[3] = 8'hE0;
    img[4] = 8'hC9; img[5] = 8'h7F; img[6] = 8'hF0;
    img[9] = 8'd77; img[10] = 8'd1; img[11] = 8'd2;
    run_img("R9 undefined");
    chk("R9 undefined no effect", int'(out_val), 77);

    // random programs
    for (int t = 0; t < 24; t++) begin
      for (int a = 0; a < 8; a++) begin
        logic [3:0] op;
        case ($urandom_range(0, 5))
          0: op = 4'h0;
          1: op = 4'h1;
          2: op = 4'h2;
          3: op = 4'hE;
          4: op = 4'($urandom_range(3, 13));
          default: op = 4'h1;
        endcase
        img[a] = {op, 4'($urandom_range(0, 15))};
      end
      img[8] = 8'hF0;
      for (int a = 9; a < 16; a++) img[a] = 8'($urandom_range(0, 255));
      run_img($sformatf("R1 random %0d", t));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule